// File: doc/BRIEF.md
# Switch destination-mask resolver

This block decides which egress ports of a small Layer-2 switch receive a frame. It keeps one shared table of port masks, loaded through a plain address/data/write-enable port. For each frame request it reads three entries of that table. The first is a destination entry, taken either from the lookup hit index or, for unknown traffic, from a flood entry picked by the frame class. The second is an aggregation entry, picked by a 4-bit flow code. The third is a source entry, picked by the ingress port. The forwarded set is the bitwise AND of the three masks, with the ingress port's own bit removed.

Mask bit j stands for physical port j, and bit N (N = `NUM_PORTS`) stands for the CPU port. The table holds 81+N entries. Entries 0..63 are destinations. Entries 0..N-1 are the single-port entries, and entry 58 is kept for CPU whitelist traffic. Entries 64..79 are aggregation entries and entries 80..80+N are source entries. The resolver is pipelined: it takes one request per cycle and answers two cycles later. Address learning, hashing and the frame datapath are outside the block.

Top module: `dst_mask_resolver`

## Requirements
- R1: While reset is low, res_valid_o and res_mask_o are 0. After reset, entry e < N holds only bit e, every source entry 80..80+N holds all ones, and every other entry holds zero.
- R2: A request with req_valid_i high at a clock edge yields res_valid_o high after exactly two edges. A new request can be accepted at every edge.
- R3: When req_hit_i is 1, the destination entry is req_dest_i (6 bits, 0..63).
- R4: When req_hit_i is 0, req_dest_i is ignored and req_cls_i selects the flood entry: 0 unknown unicast → 59, 1 non-IP multicast → 60, 2 IPv4 multicast → 61, 3 IPv6 multicast → 62, 4 broadcast → 63. Codes 5..7 are treated as broadcast (entry 63).
- R5: The aggregation entry is 64 + req_agc_i.
- R6: The source entry is 80 + req_port_i. Port value N is the CPU port.
- R7: The result mask is the bitwise AND of the destination, aggregation and source entries.
- R8: When req_port_i ≤ N, bit req_port_i of the result is 0, even if all three entries have that bit set.
- R9: When req_port_i > N, the result mask is all zero.
- R10: A write with tbl_wr_en_i high replaces the addressed entry at that clock edge. A request given at the same edge sees the new value. Writes to addresses ≥ 81+N change nothing.
- R11: Whenever res_valid_o is 0, res_mask_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_wr_en_i | input | 1 | Table write strobe |
| tbl_wr_addr_i | input | 7 | Table entry address |
| tbl_wr_data_i | input | NUM_PORTS+1 | Mask written to the entry |
| req_valid_i | input | 1 | Frame request strobe |
| req_hit_i | input | 1 | Address lookup hit |
| req_dest_i | input | 6 | Destination index on a hit |
| req_cls_i | input | 3 | Frame class for flooding |
| req_agc_i | input | 4 | Link aggregation code |
| req_port_i | input | clog2(NUM_PORTS+1) | Ingress port number |
| res_valid_o | output | 1 | Result strobe |
| res_mask_o | output | NUM_PORTS+1 | Egress port mask |

## Verification
On every cycle the assertions check four things: the two-cycle strobe timing, that the result never contains the ingress port's own bit, that an out-of-range ingress port gives an empty mask, and that an idle output is zero. They also check that unknown traffic always lands in the flood range and that an in-range write takes hold on the next cycle. Only the bench scenarios can show that the right entries are chosen and ANDed. To do this they sweep hit indices, classes, flow codes and ports against table contents that the bench chose. The bench scenarios also show the reset contents, and that writes beyond the table leave the results unchanged.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
  localparam int unsigned TBL_AW    = 7;
  localparam int unsigned DEST_IW   = 6;
  localparam int unsigned AGC_W     = 4;
  localparam int unsigned CLS_W     = 3;
  localparam int unsigned AGGR_BASE = 64;
  localparam int unsigned SRC_BASE  = 80;

  typedef enum logic [CLS_W-1:0] {
    CLS_UCAST = 3'd0,
    CLS_MC_L2 = 3'd1,
    CLS_MC_V4 = 3'd2,
    CLS_MC_V6 = 3'd3,
    CLS_BCAST = 3'd4
  } frame_cls_e;

  localparam logic [DEST_IW-1:0] FLOOD_UCAST = 6'd59;
  localparam logic [DEST_IW-1:0] FLOOD_MC_L2 = 6'd60;
  localparam logic [DEST_IW-1:0] FLOOD_MC_V4 = 6'd61;
  localparam logic [DEST_IW-1:0] FLOOD_MC_V6 = 6'd62;
  localparam logic [DEST_IW-1:0] FLOOD_BCAST = 6'd63;
endpackage

// File: rtl/dmr_dest_sel.sv
module dmr_dest_sel
  import dmr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               hit_i,
  input  logic [DEST_IW-1:0] hit_idx_i,
  input  logic [CLS_W-1:0]   cls_i,
  output logic [DEST_IW-1:0] dest_idx_o
);
  logic [DEST_IW-1:0] flood_idx;

  always_comb begin
    case (frame_cls_e'(cls_i))
      CLS_UCAST: flood_idx = FLOOD_UCAST;
      CLS_MC_L2: flood_idx = FLOOD_MC_L2;
      CLS_MC_V4: flood_idx = FLOOD_MC_V4;
      CLS_MC_V6: flood_idx = FLOOD_MC_V6;
      default:   flood_idx = FLOOD_BCAST; // undefined classes flood as broadcast
    endcase
  end

  assign dest_idx_o = hit_i ? hit_idx_i : flood_idx;

  p_flood_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !hit_i |-> dest_idx_o >= FLOOD_UCAST);
endmodule

// File: rtl/dmr_mask_table.sv
module dmr_mask_table
  import dmr_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 6,
  parameter int unsigned NUM_ENTRIES = SRC_BASE + NUM_PORTS + 1,
  parameter int unsigned MASK_W      = NUM_PORTS + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [TBL_AW-1:0] wr_addr_i,
  input  logic [MASK_W-1:0] wr_data_i,
  input  logic [TBL_AW-1:0] dst_idx_i,
  input  logic [TBL_AW-1:0] agg_idx_i,
  input  logic [TBL_AW-1:0] src_idx_i,
  output logic [MASK_W-1:0] dst_mask_o,
  output logic [MASK_W-1:0] agg_mask_o,
  output logic [MASK_W-1:0] src_mask_o
);
  logic [MASK_W-1:0] ent_q [NUM_ENTRIES];

  function automatic logic [MASK_W-1:0] init_val(int unsigned e);
    if (e < NUM_PORTS) return MASK_W'(1) << e;
    if (e >= SRC_BASE) return '1;
    return '0;
  endfunction

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     ent_q[e] <= init_val(e);
      else if (wr_en_i && wr_addr_i == TBL_AW'(e))     ent_q[e] <= wr_data_i;
    end
  end

  function automatic logic [MASK_W-1:0] rd(logic [TBL_AW-1:0] idx);
    return (32'(idx) < NUM_ENTRIES) ? ent_q[idx] : '0;
  endfunction

  assign dst_mask_o = rd(dst_idx_i);
  assign agg_mask_o = rd(agg_idx_i);
  assign src_mask_o = rd(src_idx_i);

  p_wr_take_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (32'(wr_addr_i) < NUM_ENTRIES) |=> ent_q[$past(wr_addr_i)] == $past(wr_data_i));
endmodule

// File: rtl/dst_mask_resolver.sv
module dst_mask_resolver
  import dmr_pkg::*;
#(
  parameter  int unsigned NUM_PORTS   = 6,
  localparam int unsigned MASK_W      = NUM_PORTS + 1,
  localparam int unsigned PORT_W      = $clog2(NUM_PORTS + 1),
  localparam int unsigned NUM_ENTRIES = SRC_BASE + NUM_PORTS + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tbl_wr_en_i,
  input  logic [TBL_AW-1:0]  tbl_wr_addr_i,
  input  logic [MASK_W-1:0]  tbl_wr_data_i,
  input  logic               req_valid_i,
  input  logic               req_hit_i,
  input  logic [DEST_IW-1:0] req_dest_i,
  input  logic [CLS_W-1:0]   req_cls_i,
  input  logic [AGC_W-1:0]   req_agc_i,
  input  logic [PORT_W-1:0]  req_port_i,
  output logic               res_valid_o,
  output logic [MASK_W-1:0]  res_mask_o
);
  logic [DEST_IW-1:0] dest_idx;
  logic               s1_valid_q;
  logic [DEST_IW-1:0] s1_dest_q;
  logic [AGC_W-1:0]   s1_agc_q;
  logic [PORT_W-1:0]  s1_port_q;
  logic [MASK_W-1:0]  dst_mask, agg_mask, src_mask, keep;
  logic [TBL_AW-1:0]  dst_idx, agg_idx, src_idx;

  dmr_dest_sel u_dest_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (req_valid_i),
    .hit_i      (req_hit_i),
    .hit_idx_i  (req_dest_i),
    .cls_i      (req_cls_i),
    .dest_idx_o (dest_idx)
  );

  // stage 1: resolved indices
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_dest_q  <= '0;
      s1_agc_q   <= '0;
      s1_port_q  <= '0;
    end else begin
      s1_valid_q <= req_valid_i;
      s1_dest_q  <= dest_idx;
      s1_agc_q   <= req_agc_i;
      s1_port_q  <= req_port_i;
    end
  end

  assign dst_idx = TBL_AW'(s1_dest_q);
  assign agg_idx = TBL_AW'(AGGR_BASE) + TBL_AW'(s1_agc_q);
  assign src_idx = TBL_AW'(SRC_BASE) + TBL_AW'(s1_port_q); // past table end reads as zero

  dmr_mask_table #(
    .NUM_PORTS   (NUM_PORTS),
    .NUM_ENTRIES (NUM_ENTRIES),
    .MASK_W      (MASK_W)
  ) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (tbl_wr_en_i),
    .wr_addr_i  (tbl_wr_addr_i),
    .wr_data_i  (tbl_wr_data_i),
    .dst_idx_i  (dst_idx),
    .agg_idx_i  (agg_idx),
    .src_idx_i  (src_idx),
    .dst_mask_o (dst_mask),
    .agg_mask_o (agg_mask),
    .src_mask_o (src_mask)
  );

  for (genvar b = 0; b < MASK_W; b++) begin : g_keep
    assign keep[b] = (s1_port_q != PORT_W'(b));
  end

  // stage 2: combine and register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_mask_o  <= '0;
    end else begin
      res_valid_o <= s1_valid_q;
      res_mask_o  <= s1_valid_q ? (dst_mask & agg_mask & src_mask & keep) : '0;
    end
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> ##2 res_valid_o);
  p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> ##2 !res_valid_o);
  p_no_self_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && (32'($past(req_port_i, 2)) <= NUM_PORTS) |-> !res_mask_o[$past(req_port_i, 2)]);
  p_bad_port_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && (32'($past(req_port_i, 2)) > NUM_PORTS) |-> res_mask_o == '0);
  p_idle_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> res_mask_o == '0);
endmodule

// File: tb/dst_mask_resolver_test.sv
module dst_mask_resolver_test;
  import dmr_pkg::*;
  localparam int unsigned N  = 6;
  localparam int unsigned MW = N + 1;
  localparam int unsigned PW = $clog2(N + 1);
  localparam int unsigned NE = SRC_BASE + N + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic           wr_en = 1'b0;
  logic [6:0]     wr_addr = '0;
  logic [MW-1:0]  wr_data = '0;
  logic           rq_v = 1'b0, rq_hit = 1'b0;
  logic [5:0]     rq_dest = '0;
  logic [2:0]     rq_cls = '0;
  logic [3:0]     rq_agc = '0;
  logic [PW-1:0]  rq_port = '0;
  logic           res_v;
  logic [MW-1:0]  res_m;

  dst_mask_resolver #(.NUM_PORTS(N)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .tbl_wr_en_i(wr_en), .tbl_wr_addr_i(wr_addr), .tbl_wr_data_i(wr_data),
    .req_valid_i(rq_v), .req_hit_i(rq_hit), .req_dest_i(rq_dest), .req_cls_i(rq_cls),
    .req_agc_i(rq_agc), .req_port_i(rq_port),
    .res_valid_o(res_v), .res_mask_o(res_m)
  );

  int checks = 0, fails = 0;
  logic [MW-1:0] model [128];
  logic ev1 = 1'b0, ev2 = 1'b0;
  logic [MW-1:0] em1 = '0, em2 = '0;
  string et1 = "R11", et2 = "R11";

  task automatic check(input string tag, input logic [MW-1:0] act, input logic [MW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [MW-1:0] expect_mask(logic hit, logic [5:0] di, logic [2:0] cls,
                                                logic [3:0] agc, logic [PW-1:0] port);
    int d, s;
    logic [MW-1:0] m;
    d = hit ? int'(di) : ((cls <= 3'd3) ? 59 + int'(cls) : 63);
    s = 80 + int'(port);
    m = model[d] & model[64 + int'(agc)] & ((s < int'(NE)) ? model[s] : '0);
    if (int'(port) <= int'(N)) m[port] = 1'b0;
    return m;
  endfunction

  task automatic step(input logic v, input logic hit, input logic [5:0] di, input logic [2:0] cls,
                      input logic [3:0] agc, input logic [PW-1:0] port, input string tag,
                      input logic we, input logic [6:0] wa, input logic [MW-1:0] wd);
    @(negedge clk);
    check("R2", MW'(res_v), MW'(ev2));
    check(et2, res_m, em2);
    wr_en = we; wr_addr = wa; wr_data = wd;
    rq_v = v; rq_hit = hit; rq_dest = di; rq_cls = cls; rq_agc = agc; rq_port = port;
    if (we && int'(wa) < int'(NE)) model[wa] = wd;
    ev2 = ev1; em2 = em1; et2 = et1;
    ev1 = v;
    em1 = v ? expect_mask(hit, di, cls, agc, port) : '0;
    et1 = v ? tag : "R11";
  endtask

  task automatic req(input logic hit, input int di, input int cls, input int agc, input int port,
                     input string tag);
    step(1'b1, hit, 6'(di), 3'(cls), 4'(agc), PW'(port), tag, 1'b0, '0, '0);
  endtask

  task automatic wr(input int a, input logic [MW-1:0] d);
    step(1'b0, 1'b0, '0, '0, '0, '0, "R11", 1'b1, 7'(a), d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0, '0, '0, "R11", 1'b0, '0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int e = 0; e < 128; e++)
      model[e] = (e < int'(N)) ? MW'(1) << e : ((e >= int'(SRC_BASE) && e < int'(NE)) ? '1 : '0);
    // R1: outputs quiet in reset
    repeat (3) begin
      @(negedge clk);
      check("R1", MW'(res_v), '0);
      check("R1", res_m, '0);
    end
    rst_n = 1'b1;
    // R1: aggregation entries cleared at reset, so nothing forwards
    for (int p = 0; p <= int'(N); p++) req(1'b1, p, 0, p, (p + 1) % (N + 1), "R1");
    idle(2);
    for (int c = 0; c < 16; c++) wr(64 + c, ~(MW'(1) << (c % MW)));
    // R1/R3: unicast reset entries through hit path
    for (int i = 0; i < 64; i++)
      for (int p = 0; p < (1 << PW); p++) req(1'b1, i, 0, (i + p) % 16, p, "R3");
    for (int e = N; e < 64; e++) wr(e, MW'(e * 37 + 5));
    for (int i = 0; i < 64; i++)
      for (int p = 0; p < (1 << PW); p++) req(1'b1, i, 7, (i * 3 + p) % 16, p, "R3");
    // R4/R5: flood entries by class, hit index ignored
    for (int cl = 0; cl < 8; cl++)
      for (int c = 0; c < 16; c++)
        for (int p = 0; p < (1 << PW); p++) req(1'b0, c * 3, cl, c, p, "R4");
    // R6: source entries
    for (int p = 0; p <= int'(N); p++) wr(80 + p, ~(MW'(1) << ((p + 3) % MW)));
    for (int cl = 0; cl < 5; cl++)
      for (int p = 0; p < (1 << PW); p++) req(1'b0, 0, cl, (p * 2) % 16, p, "R6");
    // R5: aggregation selects per code
    wr(30, '1);
    for (int c = 0; c < 16; c++) req(1'b1, 30, 0, c, N, "R5");
    // R7: three-way AND
    for (int p = 0; p <= int'(N); p++) req(1'b1, 30, 0, 0, p, "R7");
    for (int c = 0; c < 16; c++) req(1'b1, 40 + (c % 20), 0, c, c % (N + 1), "R7");
    // R8: own bit removed with all-ones entries
    wr(64 + 9, '1);
    for (int p = 0; p <= int'(N); p++) wr(80 + p, '1);
    for (int p = 0; p <= int'(N); p++) req(1'b1, 30, 0, 9, p, "R8");
    // R9: out-of-range ingress
    for (int p = N + 1; p < (1 << PW); p++) req(1'b1, 30, 0, 9, p, "R9");
    // R10: beyond-table writes ignored, same-cycle write visible
    wr(NE, '1); wr(127, '1); wr(NE + 5, '1);
    for (int p = N + 1; p < (1 << PW); p++) req(1'b1, 30, 0, 9, p, "R10");
    for (int i = 0; i < 64; i++) req(1'b1, i, 0, 9, i % (N + 1), "R10");
    step(1'b1, 1'b1, 6'd30, '0, 4'd9, '0, "R10", 1'b1, 7'd30, MW'(5'b10110));
    step(1'b1, 1'b1, 6'd30, '0, 4'd9, PW'(1), "R10", 1'b1, 7'd30, MW'(3));
    // R2: irregular issue pattern
    for (int i = 0; i < 24; i++)
      if (i % 3 == 1) idle(1);
      else req(1'b1, (i * 5) % 64, 0, 9, i % (N + 1), "R2");
    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule